// File: doc/BRIEF.md
# Register-List Block Transfer Sequencer

This block steps through a multi-register move between a sixteen-entry register set and a memory that is one word wide. A selection mask picks which registers take part. The caller supplies a start address, a word or long size, a direction, and a predecrement flag. On a start pulse the block emits word-bus requests one at a time. Each request gives an address, a register index, a half select and a write flag. The block holds each request until an acknowledge comes back.

Registers 0 to 7 are the data bank and registers 8 to 15 are the address bank. In predecrement mode the register index runs downward while the mask is still read from its lowest bit, and the addresses fall by one word per cycle. A move from memory into registers always ends with one spare read, whose data the consumer throws away. When the sequence ends, a one-cycle done pulse comes out together with the final running address. The register file, the memory and sign extension live outside this block.

Top module: `regblk_xfer_seq`

## Requirements
- R1: After a synchronous reset, `req_valid`, `done`, every request field and `final_addr` are zero.
- R2: Mask bits are served from bit 0 upward, one register per set bit. Clear bits produce no bus request and cost no idle cycle between requests.
- R3: The register index is split as `req_areg` = index bit 3 and `req_rnum` = index bits 2..0. Indexes 8..15 therefore name address register index-8.
- R4: In word size without predecrement, each selected register takes one request with `req_hi`=0. The address starts at `start_addr` and rises by 2 after each request.
- R5: In long size without predecrement, each register takes two requests: the high half (`req_hi`=1) at the running address, then the low half at the running address plus 2. This adds 4 per register.
- R6: With predecrement, mask bit j maps to register 15-j. The first request goes to `start_addr`-2, and each later request is 2 below the one before.
- R7: In predecrement long size, the first request of a register carries the low half and the second carries the high half, one word lower.
- R8: `req_wr` is 1 when moving registers to memory and 0 when moving memory to registers. A memory-to-register move ends with one extra read at the running address after the last register (`req_discard`=1, `req_wr`=0, `req_hi`=0, index 0).
- R9: An all-zero mask issues no register request. It issues only the extra read when the direction is memory to registers, and then signals done.
- R10: While `req_valid` is high and `ack` is low, all request outputs hold their values. The block advances only on a cycle with `ack` high.
- R11: `done` is high for exactly one cycle, with `req_valid` low. In that cycle `final_addr` equals the running address after the last register transfer; the extra read does not move it.
- R12: A `start` pulse while a sequence is running is ignored and changes nothing in the request stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a sequence (taken when idle) |
| start_addr | input | AW | First byte address of the block |
| sel_mask | input | NREG | Register selection mask |
| long_sz | input | 1 | 1 = long (two words per register), 0 = word |
| to_regs | input | 1 | 1 = memory to registers, 0 = registers to memory |
| predec | input | 1 | Predecrement (descending) mode |
| ack | input | 1 | Bus acknowledge for the current request |
| req_valid | output | 1 | Request present |
| req_addr | output | AW | Word address of the request |
| req_areg | output | 1 | 1 = address bank, 0 = data bank |
| req_rnum | output | IDXW-1 | Register number within the bank |
| req_hi | output | 1 | 1 = high half of the register |
| req_wr | output | 1 | 1 = memory write, 0 = read |
| req_discard | output | 1 | Spare trailing read, data to be dropped |
| done | output | 1 | One-cycle end-of-sequence pulse |
| final_addr | output | AW | Running address after the last register transfer |

## Verification
A sparse mask with isolated bits across both banks separates correct skipping of clear bits from per-bit stepping, and shows that the bank split is right. The same kind of mask runs in word and long size, increasing and predecrement, and in both directions. This tells apart the four address and half-order variants and shows where the spare read lands. Both directions are also run with an empty mask, and a full mask is run in long size with a second start pulse injected mid-run, to show that the pulse is ignored. Acknowledge arrives after a varying number of wait cycles, so a request that changes before it is acknowledged shows up as a mismatch.

// File: rtl/regblk_pkg.sv
package regblk_pkg;

  typedef enum logic {
    XS_IDLE = 1'b0,
    XS_RUN  = 1'b1
  } xfer_state_t;

  typedef struct packed {
    logic discard;
    logic wr;
    logic hi;
  } req_kind_t;

endpackage

// File: rtl/regblk_step.sv
module regblk_step #(
  parameter int AW     = 24,
  parameter int WBYTES = 2
) (
  input  logic [AW-1:0] a_i,
  input  logic          down_i,
  output logic [AW-1:0] a_o
);
  localparam logic [AW-1:0] STEP = AW'(WBYTES);

  assign a_o = down_i ? (a_i - STEP) : (a_i + STEP);
endmodule

// File: rtl/regblk_scan.sv
module regblk_scan #(
  parameter int NREG = 16,
  parameter int IDXW = $clog2(NREG)
) (
  input  logic [NREG-1:0] mask_i,
  output logic            any_o,
  output logic [IDXW-1:0] pos_o,
  output logic [NREG-1:0] low_oh_o
);
  logic [IDXW-1:0] acc [NREG+1];

  assign any_o    = |mask_i;
  assign low_oh_o = mask_i & (~mask_i + NREG'(1));
  assign acc[0]   = '0;

  for (genvar i = 0; i < NREG; i++) begin : g_enc
    assign acc[i+1] = acc[i] | (low_oh_o[i] ? IDXW'(i) : '0);
  end

  assign pos_o = acc[NREG];
endmodule

// File: rtl/regblk_xfer_seq.sv
module regblk_xfer_seq
  import regblk_pkg::*;
#(
  parameter int AW     = 24,
  parameter int NREG   = 16,
  parameter int WBYTES = 2,
  parameter int IDXW   = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [AW-1:0]   start_addr,
  input  logic [NREG-1:0] sel_mask,
  input  logic            long_sz,
  input  logic            to_regs,
  input  logic            predec,
  input  logic            ack,
  output logic            req_valid,
  output logic [AW-1:0]   req_addr,
  output logic            req_areg,
  output logic [IDXW-2:0] req_rnum,
  output logic            req_hi,
  output logic            req_wr,
  output logic            req_discard,
  output logic            done,
  output logic [AW-1:0]   final_addr
);
  localparam logic [IDXW-1:0] TOP_IDX = IDXW'(NREG - 1);

  xfer_state_t     state_q;
  logic            second_q, predec_q, long_q, toreg_q;
  logic [NREG-1:0] rem_q;
  logic [AW-1:0]   run_q;

  logic            valid_q, done_q;
  logic [AW-1:0]   addr_q, final_q;
  logic [IDXW-1:0] idx_q;
  req_kind_t       kind_q;

  logic            busy, launch, acked;
  logic            cur_predec, cur_long, cur_toreg;
  logic [NREG-1:0] scan_in, scan_oh;
  logic            scan_any;
  logic [IDXW-1:0] scan_pos, reg_idx;
  logic [AW-1:0]   start_back, run_src, run_adv;

  assign busy       = (state_q == XS_RUN);
  assign launch     = !busy && start;
  assign acked      = busy && valid_q && ack;
  assign cur_predec = busy ? predec_q : predec;
  assign cur_long   = busy ? long_q   : long_sz;
  assign cur_toreg  = busy ? toreg_q  : to_regs;
  assign scan_in    = busy ? rem_q    : sel_mask;

  regblk_step #(.AW(AW), .WBYTES(WBYTES)) u_step_start (
    .a_i(start_addr), .down_i(1'b1), .a_o(start_back)
  );

  assign run_src = busy ? run_q : (predec ? start_back : start_addr);

  regblk_step #(.AW(AW), .WBYTES(WBYTES)) u_step_run (
    .a_i(run_src), .down_i(cur_predec), .a_o(run_adv)
  );

  regblk_scan #(.NREG(NREG), .IDXW(IDXW)) u_scan (
    .mask_i(scan_in), .any_o(scan_any), .pos_o(scan_pos), .low_oh_o(scan_oh)
  );

  assign reg_idx = cur_predec ? (TOP_IDX - scan_pos) : scan_pos;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= XS_IDLE;
      second_q <= 1'b0;
      predec_q <= 1'b0;
      long_q   <= 1'b0;
      toreg_q  <= 1'b0;
      rem_q    <= '0;
      run_q    <= '0;
      valid_q  <= 1'b0;
      done_q   <= 1'b0;
      addr_q   <= '0;
      final_q  <= '0;
      idx_q    <= '0;
      kind_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (launch) begin
        predec_q <= predec;
        long_q   <= long_sz;
        toreg_q  <= to_regs;
        state_q  <= XS_RUN;
      end
      if (acked && second_q) begin
        // second word of a long register: other half, next word address
        addr_q    <= run_src;
        kind_q.hi <= ~kind_q.hi;
        run_q     <= run_adv;
        second_q  <= 1'b0;
      end else if (launch || (acked && !kind_q.discard)) begin
        if (scan_any) begin
          valid_q  <= 1'b1;
          addr_q   <= run_src;
          idx_q    <= reg_idx;
          kind_q   <= '{discard: 1'b0, wr: ~cur_toreg,
                        hi: cur_long & ~cur_predec};
          run_q    <= run_adv;
          second_q <= cur_long;
          rem_q    <= scan_in & ~scan_oh;
        end else if (cur_toreg) begin
          valid_q <= 1'b1;
          addr_q  <= run_src;
          idx_q   <= '0;
          kind_q  <= '{discard: 1'b1, wr: 1'b0, hi: 1'b0};
          run_q   <= run_src;
          rem_q   <= '0;
        end else begin
          valid_q <= 1'b0;
          addr_q  <= '0;
          idx_q   <= '0;
          kind_q  <= '0;
          state_q <= XS_IDLE;
          done_q  <= 1'b1;
          final_q <= run_src;
        end
      end else if (acked) begin
        // spare trailing read acknowledged
        valid_q <= 1'b0;
        addr_q  <= '0;
        idx_q   <= '0;
        kind_q  <= '0;
        state_q <= XS_IDLE;
        done_q  <= 1'b1;
        final_q <= run_q;
      end
    end
  end

  assign req_valid   = valid_q;
  assign req_addr    = addr_q;
  assign req_areg    = idx_q[IDXW-1];
  assign req_rnum    = idx_q[IDXW-2:0];
  assign req_hi      = kind_q.hi;
  assign req_wr      = kind_q.wr;
  assign req_discard = kind_q.discard;
  assign done        = done_q;
  assign final_addr  = final_q;
endmodule

// File: rtl/regblk_xfer_seq_chk.sv
module regblk_xfer_seq_chk #(
  parameter int AW     = 24,
  parameter int RW     = 3,
  parameter int WBYTES = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          ack,
  input logic          req_valid,
  input logic [AW-1:0] req_addr,
  input logic          req_areg,
  input logic [RW-1:0] req_rnum,
  input logic          req_hi,
  input logic          req_wr,
  input logic          req_discard,
  input logic          done
);
  localparam logic [AW-1:0] STEP = AW'(WBYTES);

  a_r10_hold_request: assert property (@(posedge clk) disable iff (rst)
    req_valid && !ack |=> req_valid && $stable(req_addr) && $stable(req_areg)
      && $stable(req_rnum) && $stable(req_hi) && $stable(req_wr)
      && $stable(req_discard));

  a_r11_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r11_done_quiet: assert property (@(posedge clk) disable iff (rst)
    done |-> !req_valid);

  a_r8_discard_is_read: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_discard |-> !req_wr && !req_hi);

  a_r4_word_step: assert property (@(posedge clk) disable iff (rst)
    req_valid && ack && !req_discard |=> !req_valid
      || (req_addr == $past(req_addr) + STEP)
      || (req_addr == $past(req_addr) - STEP));
endmodule

bind regblk_xfer_seq regblk_xfer_seq_chk #(
  .AW(AW), .RW(IDXW - 1), .WBYTES(WBYTES)
) i_chk (
  .clk(clk), .rst(rst), .ack(ack), .req_valid(req_valid),
  .req_addr(req_addr), .req_areg(req_areg), .req_rnum(req_rnum),
  .req_hi(req_hi), .req_wr(req_wr), .req_discard(req_discard), .done(done)
);

// File: tb/test_regblk_xfer_seq.sv
module test_regblk_xfer_seq;
  localparam int AW = 24;
  localparam int NREG = 16;
  typedef logic [AW+6:0] item_t; // discard, wr, hi, areg, rnum[2:0], addr

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, ack = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic [NREG-1:0] sel_mask = '0;
  logic long_sz = 1'b0, to_regs = 1'b0, predec = 1'b0;
  logic req_valid, req_areg, req_hi, req_wr, req_discard, done;
  logic [AW-1:0] req_addr, final_addr;
  logic [2:0] req_rnum;

  int checks = 0, errors = 0, seen = 0;
  item_t exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  regblk_xfer_seq i_regblk_xfer_seq (
    .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
    .sel_mask(sel_mask), .long_sz(long_sz), .to_regs(to_regs),
    .predec(predec), .ack(ack), .req_valid(req_valid), .req_addr(req_addr),
    .req_areg(req_areg), .req_rnum(req_rnum), .req_hi(req_hi),
    .req_wr(req_wr), .req_discard(req_discard), .done(done),
    .final_addr(final_addr)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  function automatic item_t mk(input logic d, input logic w, input logic h,
                               input logic [3:0] idx, input logic [AW-1:0] a);
    return {d, w, h, idx, a};
  endfunction

  // monitor: pops expected items, acks after a varying wait
  initial begin
    item_t act, cur, e;
    string t;
    bit holding = 0;
    int gap = 0, gseed = 1;
    cur = '0;
    forever begin
      @(negedge clk);
      if (rst) begin
        ack = 1'b0;
        holding = 0;
      end else if (ack) begin
        ack = 1'b0;
        holding = 0;
      end else if (req_valid) begin
        act = {req_discard, req_wr, req_hi, req_areg, req_rnum, req_addr};
        if (!holding) begin
          holding = 1;
          seen++;
          cur = act;
          if (exp_q.size() == 0) begin
            chk(0, "R2", "unexpected request", 64'(act), 0);
          end else begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk({act[AW+6:AW+4], act[AW-1:0]} == {e[AW+6:AW+4], e[AW-1:0]},
                t, "request flags/address", 64'(act), 64'(e));
            if (!e[AW+6])
              chk(act[AW+3:AW] == e[AW+3:AW], "R3", "bank/register",
                  64'(act[AW+3:AW]), 64'(e[AW+3:AW]));
          end
          gseed = (gseed * 5 + 3) & 7;
          gap = gseed % 3;
        end else begin
          chk(act == cur, "R10", "request changed before ack",
              64'(act), 64'(cur));
        end
        if (gap == 0) ack = 1'b1;
        else gap--;
      end
    end
  end

  task automatic run_xfer(input logic [AW-1:0] a, input logic [15:0] m,
                          input bit lg, input bit tr, input bit pd,
                          input bit poke);
    logic [AW-1:0] r;
    logic [3:0] idx;
    string t;
    int n_exp = 0, base, cnt = 0;
    bit got;
    r = pd ? a - AW'(2) : a;
    t = pd ? (lg ? "R7" : "R6") : (lg ? "R5" : "R4");
    for (int j = 0; j < 16; j++) begin
      if (m[j]) begin
        idx = pd ? 4'(15 - j) : 4'(j);
        if (lg) begin
          exp_q.push_back(mk(1'b0, !tr, !pd, idx, r)); tag_q.push_back(t);
          r = pd ? r - AW'(2) : r + AW'(2);
          exp_q.push_back(mk(1'b0, !tr, pd, idx, r)); tag_q.push_back(t);
          r = pd ? r - AW'(2) : r + AW'(2);
          n_exp += 2;
        end else begin
          exp_q.push_back(mk(1'b0, !tr, 1'b0, idx, r)); tag_q.push_back(t);
          r = pd ? r - AW'(2) : r + AW'(2);
          n_exp += 1;
        end
      end
    end
    if (tr) begin
      exp_q.push_back(mk(1'b1, 1'b0, 1'b0, 4'd0, r)); tag_q.push_back("R8");
      n_exp += 1;
    end
    base = seen;
    @(negedge clk);
    start_addr = a; sel_mask = m; long_sz = lg; to_regs = tr; predec = pd;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    got = done;
    while (!got && cnt < 3000) begin
      @(negedge clk);
      cnt++;
      if (poke && cnt == 3) begin
        start = 1'b1; sel_mask = ~m; predec = !pd; to_regs = !tr;
        start_addr = a + AW'(100);
      end else if (poke && cnt == 4) begin
        start = 1'b0;
      end
      got = done;
    end
    chk(got, "R11", "done seen", 64'(got), 1);
    chk(final_addr == r, "R11", "final address", 64'(final_addr), 64'(r));
    chk(seen - base == n_exp, (m == 0) ? "R9" : "R2", "request count",
        64'(seen - base), 64'(n_exp));
    chk(exp_q.size() == 0, "R2", "missing requests", 64'(exp_q.size()), 0);
    exp_q.delete(); tag_q.delete();
    @(negedge clk);
    chk(!done, "R11", "done longer than one cycle", 64'(done), 0);
    if (poke) begin
      for (int k = 0; k < 5; k++) begin
        @(negedge clk);
        chk(!req_valid, "R12", "activity after ignored start",
            64'(req_valid), 0);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!req_valid && !done, "R1", "valid/done after reset",
        64'({req_valid, done}), 0);
    chk(req_addr == 0 && final_addr == 0 && !req_hi && !req_wr
        && !req_discard && !req_areg && req_rnum == 0, "R1",
        "fields after reset", 64'(req_addr), 0);
    run_xfer(24'h001000, 16'h8421, 1'b0, 1'b0, 1'b0, 1'b0);
    run_xfer(24'h003000, 16'h0181, 1'b1, 1'b0, 1'b0, 1'b0);
    run_xfer(24'h004000, 16'hF000, 1'b0, 1'b1, 1'b0, 1'b0);
    run_xfer(24'h005000, 16'h0181, 1'b1, 1'b1, 1'b0, 1'b0);
    run_xfer(24'h002000, 16'h0003, 1'b0, 1'b0, 1'b1, 1'b0);
    run_xfer(24'h002100, 16'h8421, 1'b0, 1'b0, 1'b1, 1'b0);
    run_xfer(24'h006000, 16'h8001, 1'b1, 1'b0, 1'b1, 1'b0);
    run_xfer(24'h007000, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b0);
    run_xfer(24'h007100, 16'h0000, 1'b0, 1'b1, 1'b0, 1'b0);
    run_xfer(24'h008000, 16'hFFFF, 1'b1, 1'b1, 1'b0, 1'b1);
    run_xfer(24'h000002, 16'h0001, 1'b1, 1'b0, 1'b1, 1'b0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule